// File: doc/BRIEF.md
# Gated-Input General-Purpose I/O Port

This block is a 16-pin general-purpose I/O port whose pins can also serve as analog converter inputs. Each pin has a stored data bit, a direction bit and a digital-input-enable bit. The three registers are split into a high byte (pins 15..8) and a low byte (pins 7..0). A synchronous byte-wide register bus reads and writes them at any time. The block drives a level and an output enable to each pad and takes in the raw level from the pad.

A read of the data register returns one value per pin:
- A pin set as an output returns its stored bit.
- An input pin whose digital buffer is enabled returns its synchronized pad level.
- An input pin whose buffer is disabled returns a constant 1, so an unused analog pin reads as high and does not float.

Out of reset every register is clear, so every pin is a high-impedance input with its digital buffer off.

Top module: `gpio_port_gate`

## Requirements
- R1: While reset is held, and just after it is released, all data, direction and input-enable bits are 0. As a result `pad_oe_o` and `pad_out_o` are 0, the direction and input-enable addresses read 0x00, and both data addresses read 0xFF.
- R2: A bus write to a data address stores the byte at the clock edge. From the next cycle `pad_out_o` carries the stored bits in that byte lane.
- R3: `pad_oe_o` for each pin equals that pin's direction bit, from the cycle after the direction write.
- R4: A data write to a pin whose direction bit is 0 updates the stored bit and leaves that pin's `pad_oe_o` at 0, so the pad is not driven.
- R5: When a pin's direction bit changes from 0 to 1, the pin drives, in the next cycle, the data bit last written while it was an input.
- R6: A read of a data address returns the stored data bit for every pin whose direction bit is 1, whatever the pad level.
- R7: A read of a data address returns 1 for every pin whose direction bit is 0 and whose input-enable bit is 0.
- R8: For a pin whose direction bit is 0 and whose input-enable bit is 1, a data read returns the pad level after a two-flop synchronizer. A pad change shows on reads after the second rising clock edge, and not after the first.
- R9: The direction and input-enable registers read back the last byte written to them.
- R10: Addresses 6 and 7 are unmapped. They read 0x00, and writes to them change no register.
- R11: The address map is: 0 = data high, 1 = data low, 2 = direction high, 3 = direction low, 4 = input-enable high, 5 = input-enable low. A high byte maps to pins 15..8 and a low byte to pins 7..0, with bit n of a byte on pin 8·lane+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| pad_out_o | output | 16 | Level driven to each pad |
| pad_oe_o | output | 16 | Output enable to each pad |
| pad_in_i | input | 16 | Raw pad levels |

## Verification
The assertions assume the following about the inputs:
- `bus_addr_i`, `bus_we_i` and `bus_wdata_i` are stable across each rising edge.
- The pad inputs may change at any time, but the synchronizer check compares a read against the pad level sampled two edges earlier. It is therefore only meaningful once two edges have passed since reset, which the checker counts itself.

The stimulus keeps within these assumptions. It changes bus and pad inputs only on the falling edge, then waits at least three cycles after a pad change before an ordinary data read. The one exception is the directed latency test, which samples one and two edges after the change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // register kinds; address = kind * lanes + (lanes - 1 - lane)
  typedef enum logic [1:0] {
    RK_DATA = 2'd0,
    RK_DIR  = 2'd1,
    RK_IEN  = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  localparam int unsigned NUM_KINDS = 3;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ADDR_W   = 3,
  localparam int unsigned NUM_LANES = NUM_PINS / BYTE_W,
  localparam int unsigned LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BYTE_W-1:0]   bus_wdata_i,
  output reg_kind_e           sel_kind_o,
  output logic [LANE_W-1:0]   sel_lane_o,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] ien_o
);
  localparam int unsigned NUM_ADDR = NUM_KINDS * NUM_LANES;

  reg_kind_e         kind;
  logic [LANE_W-1:0] lane;

  always_comb begin
    int unsigned a;
    a = 32'(bus_addr_i);
    if (a < NUM_ADDR) begin
      kind = reg_kind_e'(2'(a / NUM_LANES));
      lane = LANE_W'(NUM_LANES - 1 - (a % NUM_LANES));
    end else begin
      kind = RK_NONE;
      lane = '0;
    end
  end

  assign sel_kind_o = kind;
  assign sel_lane_o = lane;

  logic wr;
  assign wr = bus_en_i & bus_we_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[l*BYTE_W +: BYTE_W] <= '0;
        dir_o[l*BYTE_W +: BYTE_W]  <= '0;
        ien_o[l*BYTE_W +: BYTE_W]  <= '0;
      end else if (wr && (32'(lane) == l)) begin
        unique case (kind)
          RK_DATA: data_o[l*BYTE_W +: BYTE_W] <= bus_wdata_i;
          RK_DIR:  dir_o[l*BYTE_W +: BYTE_W]  <= bus_wdata_i;
          RK_IEN:  ien_o[l*BYTE_W +: BYTE_W]  <= bus_wdata_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned NUM_LANES = NUM_PINS / BYTE_W,
  localparam int unsigned LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  reg_kind_e           sel_kind_i,
  input  logic [LANE_W-1:0]   sel_lane_i,
  input  logic [NUM_PINS-1:0] data_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] ien_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  output logic [BYTE_W-1:0]   rdata_o
);
  logic [NUM_PINS-1:0] pin_rd;

  // output: stored bit; input+buffer on: pad; input+buffer off: 1
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin_rd[i] = dir_i[i] ? data_i[i] : (ien_i[i] ? pin_sync_i[i] : 1'b1);
  end

  always_comb begin
    unique case (sel_kind_i)
      RK_DATA: rdata_o = pin_rd[sel_lane_i*BYTE_W +: BYTE_W];
      RK_DIR:  rdata_o = dir_i[sel_lane_i*BYTE_W +: BYTE_W];
      RK_IEN:  rdata_o = ien_i[sel_lane_i*BYTE_W +: BYTE_W];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_gate.sv
module gpio_port_gate
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BYTE_W-1:0]   bus_wdata_i,
  output logic [BYTE_W-1:0]   bus_rdata_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_PINS-1:0] pad_in_i
);
  localparam int unsigned NUM_LANES = NUM_PINS / BYTE_W;
  localparam int unsigned LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  reg_kind_e           sel_kind;
  logic [LANE_W-1:0]   sel_lane;
  logic [NUM_PINS-1:0] data_q, dir_q, ien_q, pin_sync;

  gpio_port_regs #(
    .NUM_PINS(NUM_PINS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .bus_en_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .sel_kind_o(sel_kind), .sel_lane_o(sel_lane),
    .data_o(data_q), .dir_o(dir_q), .ien_o(ien_q)
  );

  gpio_port_sync #(
    .WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_sync)
  );

  gpio_port_rdmux #(
    .NUM_PINS(NUM_PINS), .BYTE_W(BYTE_W)
  ) u_rdmux (
    .sel_kind_i(sel_kind), .sel_lane_i(sel_lane),
    .data_i(data_q), .dir_i(dir_q), .ien_i(ien_q),
    .pin_sync_i(pin_sync), .rdata_o(bus_rdata_o)
  );

  assign pad_out_o = data_q;
  assign pad_oe_o  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ADDR_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_en_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [BYTE_W-1:0]   bus_wdata_i,
  input logic [BYTE_W-1:0]   bus_rdata_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] ien_q
);
  localparam int unsigned NUM_LANES = NUM_PINS / BYTE_W;
  localparam logic [ADDR_W-1:0] A_DATA_LO = ADDR_W'(NUM_LANES - 1);
  localparam logic [ADDR_W-1:0] A_DIR_LO  = ADDR_W'(2*NUM_LANES - 1);
  localparam int unsigned       NUM_ADDR  = 3 * NUM_LANES;

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  logic rd_data_lo;
  assign rd_data_lo = bus_en_i && !bus_we_i && bus_addr_i == A_DATA_LO;

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_idle_R1: assert (pad_oe_o == '0 && pad_out_o == '0);

  assert_data_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_i && bus_we_i && bus_addr_i == A_DATA_LO
      |=> pad_out_o[BYTE_W-1:0] == $past(bus_wdata_i));

  assert_dir_to_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_i && bus_we_i && bus_addr_i == A_DIR_LO
      |=> pad_oe_o[BYTE_W-1:0] == $past(bus_wdata_i));

  assert_output_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_lo |-> (pad_oe_o[BYTE_W-1:0] & (bus_rdata_o ^ pad_out_o[BYTE_W-1:0])) == '0);

  assert_gated_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_lo |-> (~pad_oe_o[BYTE_W-1:0] & ~ien_q[BYTE_W-1:0] & ~bus_rdata_o) == '0);

  assert_sync_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_lo && cyc_q >= 2'd2
      |-> ((~pad_oe_o[BYTE_W-1:0] & ien_q[BYTE_W-1:0])
           & (bus_rdata_o ^ $past(pad_in_i[BYTE_W-1:0], 2))) == '0);

  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_i && !bus_we_i && 32'(bus_addr_i) >= NUM_ADDR |-> bus_rdata_o == '0);
endmodule

bind gpio_port_gate gpio_port_chk #(
  .NUM_PINS(NUM_PINS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i, .rst_ni, .bus_en_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
  .bus_rdata_o, .pad_out_o, .pad_oe_o, .pad_in_i, .ien_q(ien_q)
);

// File: tb/gpio_port_gate_bench.sv
module gpio_port_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pad_out, pad_oe;
  logic [15:0] pad_in = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port_gate u_gpio_port_gate (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_in_i(pad_in)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); en = 1; we = 0; addr = a;
    #1 d = rdata;
    en = 0;
  endtask

  task automatic set_pad(input logic [15:0] v);
    @(negedge clk); pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  // {kind(0 wr,1 rd,2 pad), addr, data, expected read, requirement number}
  localparam int NV = 19;
  localparam logic [32:0] VECS [NV] = '{
    {2'd1, 3'd0, 16'h0000, 8'hFF, 4'd1},  // R1 data hi reads 1s
    {2'd1, 3'd2, 16'h0000, 8'h00, 4'd1},  // R1 dir hi clear
    {2'd1, 3'd5, 16'h0000, 8'h00, 4'd1},  // R1 ien lo clear
    {2'd0, 3'd1, 16'h00A5, 8'h00, 4'd0},
    {2'd1, 3'd1, 16'h0000, 8'hFF, 4'd7},  // R7 gated input
    {2'd0, 3'd5, 16'h00F0, 8'h00, 4'd0},
    {2'd1, 3'd5, 16'h0000, 8'hF0, 4'd9},  // R9
    {2'd2, 3'd0, 16'h3C5A, 8'h00, 4'd0},
    {2'd1, 3'd1, 16'h0000, 8'h5F, 4'd8},  // R8 upper nibble from pad
    {2'd0, 3'd3, 16'h000F, 8'h00, 4'd0},
    {2'd1, 3'd1, 16'h0000, 8'h55, 4'd6},  // R6 low nibble stored
    {2'd1, 3'd3, 16'h0000, 8'h0F, 4'd9},  // R9
    {2'd0, 3'd2, 16'h00FF, 8'h00, 4'd0},
    {2'd0, 3'd0, 16'h00C3, 8'h00, 4'd0},
    {2'd1, 3'd0, 16'h0000, 8'hC3, 4'd6},  // R6 pad hi is 3C
    {2'd1, 3'd6, 16'h0000, 8'h00, 4'd10}, // R10
    {2'd1, 3'd7, 16'h0000, 8'h00, 4'd10}, // R10
    {2'd0, 3'd4, 16'h000F, 8'h00, 4'd0},
    {2'd1, 3'd4, 16'h0000, 8'h0F, 4'd9}   // R9
  };

  initial begin
    logic [7:0] r;
    #1;
    check("R1 oe in reset", pad_oe, 16'h0000);
    check("R1 out in reset", pad_out, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VECS[i];
      case (v[32:31])
        2'd0: bus_wr(v[30:28], v[19:12]);
        2'd1: begin
          bus_rd(v[30:28], r);
          check($sformatf("R%0d vector %0d", v[3:0], i), {8'h00, r}, {8'h00, v[11:4]});
        end
        default: set_pad(v[27:12]);
      endcase
    end

    // R3 R11 lanes map to pin halves
    check("R3 R11 oe", pad_oe, 16'hFF0F);
    check("R2 R11 out", pad_out, 16'hC3A5);

    // R4 data write to input pins leaves them undriven
    bus_wr(3'd1, 8'h5A);
    check("R4 oe unchanged", pad_oe, 16'hFF0F);
    check("R2 stored lo", pad_out, 16'hC35A);

    // R5 turn inputs into outputs: last written data driven
    bus_wr(3'd3, 8'hFF);
    check("R5 oe", pad_oe, 16'hFFFF);
    check("R5 out", pad_out, 16'hC35A);
    bus_rd(3'd1, r);
    check("R5 read", {8'h00, r}, 16'h005A);

    // R10 writes to unmapped addresses have no effect
    bus_wr(3'd6, 8'h00);
    bus_wr(3'd7, 8'h00);
    bus_rd(3'd3, r);
    check("R10 dir lo kept", {8'h00, r}, 16'h00FF);
    bus_rd(3'd1, r);
    check("R10 data lo kept", {8'h00, r}, 16'h005A);
    check("R10 pads kept", pad_oe, 16'hFFFF);

    // R8 latency: visible after two edges, not one
    bus_wr(3'd3, 8'h00);
    bus_wr(3'd5, 8'hFF);
    set_pad(16'h0000);
    @(negedge clk); pad_in = 16'h0081; en = 1; we = 0; addr = 3'd1;
    #1 check("R8 before edge", {8'h00, rdata}, 16'h0000);
    @(negedge clk); #1 check("R8 one edge", {8'h00, rdata}, 16'h0000);
    @(negedge clk); #1 check("R8 two edges", {8'h00, rdata}, 16'h0081);
    en = 0;

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    #1 check("R1 oe after reset", pad_oe, 16'h0000);
    check("R1 out after reset", pad_out, 16'h0000);
    @(negedge clk); rst_n = 1;
    bus_rd(3'd2, r);
    check("R1 dir hi", {8'h00, r}, 16'h0000);
    bus_rd(3'd0, r);
    check("R1 data hi", {8'h00, r}, 16'h00FF);
    bus_rd(3'd5, r);
    check("R1 ien lo", {8'h00, r}, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule